// File: doc/BRIEF.md
# Packet Data Pointer Port

This block gives a host indirect access to a packet buffer through three registers: a packet-number register, a pointer register and a data register. The pointer register holds an offset into one packet and three mode flags. One flag chooses the packet. It is either the packet at the head of the receive queue, which arrives on an input, or the packet held in the packet-number register. A second flag sets the transfer direction. The third makes the offset advance by the width of each data access. The host then streams bytes or 16-bit words in or out through the data register.

The buffer is an internal byte RAM. Each packet number owns a fixed run of 256-byte pages, and the offset wraps inside that run. In read mode the block fetches the addressed bytes into a holding register ahead of time, so a data read returns at once. The port is busy for exactly one cycle while each fetch completes.

The block's behaviour is set by a small state machine with three states. ST_IDLE is write mode, with nothing prefetched. ST_FETCH lasts one cycle while the RAM loads the two bytes at the offset. ST_READY means the prefetched bytes are valid. The transitions are:
- T_PTR_RD: a pointer write with the read flag set goes from any state to ST_FETCH.
- T_PTR_WR: a pointer write with the read flag clear goes from any state to ST_IDLE.
- T_PKT_REFETCH: a packet-number write while in read mode goes to ST_FETCH.
- T_FETCH_DONE: ST_FETCH always goes to ST_READY.
- T_READ_ADV: an accepted data read with auto-increment goes from ST_READY to ST_FETCH.

Otherwise the state holds.

Top module: `ppp_data_port`

## Requirements
- R1: After reset the packet-number register and the pointer register read 0, and `busy` is 0.
- R2: Register select codes are 0 for the packet number, 1 for the pointer and 2 for data. The packet number reads back zero-extended. The pointer reads back with bit 15 as the receive-select flag, bit 14 as auto-increment, bit 13 as read, bits 12:11 as 0 and bits 10:0 as the offset.
- R3: With pointer bit 15 set, data accesses target the packet on `rx_head_pkt`. With bit 15 clear, they target the packet-number register. Each packet owns PAGES_PER_PKT pages of 256 bytes.
- R4: A word access moves two bytes. Bits 7:0 go to or come from the offset, and bits 15:8 go to or come from offset+1, even when the offset is odd.
- R5: A byte access (`acc_byte`=1) writes `wdata[7:0]` at the offset. A byte read returns the byte in bits 7:0, with bits 15:8 at 0.
- R6: With auto-increment set, every accepted data access advances the offset by 1 for a byte and by 2 for a word.
- R7: With auto-increment clear, the offset holds, and repeated reads return the same data.
- R8: A written offset is reduced modulo the packet size (512 bytes by default). Both advances and the second byte of a word wrap to offset 0 of the same packet.
- R9: A pointer write with the read flag set, a packet-number write in read mode, and an auto-incrementing data read each make `busy` 1 for the next cycle only. After that, the data register returns the bytes at the new offset.
- R10: The following data accesses are ignored and change neither the buffer nor the offset: writes while the read flag is set, reads while it is clear, and any data access while `busy` is 1. A data read returns 0 unless the prefetch is valid.
- R11: Register select code 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select (0 packet number, 1 pointer, 2 data) |
| rd_en | input | 1 | Read strobe for the selected register |
| wr_en | input | 1 | Write strobe for the selected register |
| acc_byte | input | 1 | 1 for an 8-bit data access, 0 for 16-bit |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register, combinational |
| busy | output | 1 | Prefetch in progress; data accesses ignored |
| rx_head_pkt | input | PKT_W | Packet number at the head of the receive queue |

## Verification
Register reads are combinational, so the bench compares `rdata` a quarter period after it drives the select, in the same cycle. A pointer or packet-number write shows up in a readback on the following cycle. A pointer write with the read flag, or an auto-incrementing read, raises `busy` for exactly the next cycle, and the new prefetched data is due one cycle after that. The bench therefore puts one idle cycle after each such stimulus, checks `busy` in that cycle, and only then reads the data register. A scoreboard queue lines each expected read value up with the cycle in which the monitor samples it.

// File: rtl/ppp_pkg.sv
package ppp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_READY = 2'd2
    } port_state_e;

    localparam logic [1:0] SEL_PKT  = 2'd0;
    localparam logic [1:0] SEL_PTR  = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam int BIT_RXSEL = 15;
    localparam int BIT_AUTO  = 14;
    localparam int BIT_READ  = 13;

endpackage

// File: rtl/ppp_ptr_reg.sv
// Packet-number and pointer registers, including the offset advance.
module ppp_ptr_reg #(
    parameter int PKT_W = 2,
    parameter int OFF_W = 11,
    parameter int LOC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_wr,
    input  logic [PKT_W-1:0] pkt_in,
    input  logic             ptr_wr,
    input  logic [2:0]       flags_in,
    input  logic [LOC_W-1:0] off_in,
    input  logic             adv,
    input  logic             adv_byte,
    output logic [PKT_W-1:0] pkt_q,
    output logic             rx_sel,
    output logic             auto_inc,
    output logic             rd_mode,
    output logic [OFF_W-1:0] off_q
);

    logic [LOC_W-1:0] loc_q;
    logic [LOC_W-1:0] step;

    assign step  = adv_byte ? LOC_W'(1) : LOC_W'(2);
    assign off_q = OFF_W'(loc_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_q    <= '0;
            rx_sel   <= 1'b0;
            auto_inc <= 1'b0;
            rd_mode  <= 1'b0;
            loc_q    <= '0;
        end else begin
            if (pkt_wr) begin
                pkt_q <= pkt_in;
            end
            if (ptr_wr) begin
                {rx_sel, auto_inc, rd_mode} <= flags_in;
                loc_q <= off_in;
            end else if (adv) begin
                loc_q <= loc_q + step;   // natural wrap at the packet size
            end
        end
    end

endmodule

// File: rtl/ppp_addr_gen.sv
// Physical byte addresses of the two lanes of an access.
module ppp_addr_gen #(
    parameter int PKT_W = 2,
    parameter int LOC_W = 9,
    parameter int AW    = PKT_W + LOC_W
) (
    input  logic [PKT_W-1:0]        pkt,
    input  logic [LOC_W-1:0]        loc,
    output logic [1:0][AW-1:0]      lane_addr
);

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [LOC_W-1:0] lane_loc;
        assign lane_loc     = loc + LOC_W'(g);
        assign lane_addr[g] = {pkt, lane_loc};
    end

endmodule

// File: rtl/ppp_pkt_ram.sv
// Byte-organised packet buffer: two write lanes, two registered read lanes.
module ppp_pkt_ram #(
    parameter int AW = 11
) (
    input  logic               clk,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [1:0][AW-1:0] addr,
    input  logic [15:0]        wdata,
    input  logic               rd_en,
    output logic [7:0]         rd_lo,
    output logic [7:0]         rd_hi
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_lo) begin
            mem[addr[0]] <= wdata[7:0];
        end
        if (wr_hi) begin
            mem[addr[1]] <= wdata[15:8];
        end
        if (rd_en) begin
            rd_lo <= mem[addr[0]];
            rd_hi <= mem[addr[1]];
        end
    end

endmodule

// File: rtl/ppp_ctrl_fsm.sv
// Prefetch sequencing.
module ppp_ctrl_fsm
    import ppp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_wr,
    input  logic        ptr_wr_read,
    input  logic        pkt_wr,
    input  logic        rd_mode,
    input  logic        rd_adv,
    output port_state_e state_q,
    output logic        busy,
    output logic        fetch_en,
    output logic        data_ready
);

    port_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (ptr_wr) begin
            state_d = ptr_wr_read ? ST_FETCH : ST_IDLE;       // T_PTR_RD / T_PTR_WR
        end else if (pkt_wr && rd_mode) begin
            state_d = ST_FETCH;                               // T_PKT_REFETCH
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FETCH: state_d = ST_READY;                 // T_FETCH_DONE
                ST_READY: state_d = rd_adv ? ST_FETCH : ST_READY; // T_READ_ADV
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = 1'b0;
        fetch_en   = 1'b0;
        data_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: begin
                busy     = 1'b1;
                fetch_en = 1'b1;
            end
            ST_READY: data_ready = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/ppp_data_port.sv
// Indirect packet-buffer access port.
module ppp_data_port
    import ppp_pkg::*;
#(
    parameter int PKT_W         = 2,
    parameter int PAGES_PER_PKT = 2,
    parameter int PAGE_BYTES    = 256,
    parameter int OFF_W         = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic             acc_byte,
    input  logic [15:0]      wdata,
    output logic [15:0]      rdata,
    output logic             busy,
    input  logic [PKT_W-1:0] rx_head_pkt
);

    localparam int PKT_BYTES = PAGES_PER_PKT * PAGE_BYTES;
    localparam int LOC_W     = $clog2(PKT_BYTES);
    localparam int AW        = PKT_W + LOC_W;

    logic             ptr_wr, pkt_wr;
    logic             data_rd_ok, data_wr_ok, adv;
    logic [PKT_W-1:0] pkt_q, target_pkt;
    logic             ptr_rxsel, ptr_auto, ptr_read;
    logic [OFF_W-1:0] ptr_off;
    logic [1:0][AW-1:0] lane_addr;
    logic [7:0]       ram_lo, ram_hi;
    logic             fetch_en, data_ready;
    port_state_e      state_q;
    logic [15:0]      ptr_view;

    assign ptr_wr     = wr_en && (reg_sel == SEL_PTR);
    assign pkt_wr     = wr_en && (reg_sel == SEL_PKT);
    assign data_rd_ok = rd_en && (reg_sel == SEL_DATA) && ptr_read && data_ready;
    assign data_wr_ok = wr_en && (reg_sel == SEL_DATA) && !ptr_read && !busy;
    assign adv        = (data_rd_ok || data_wr_ok) && ptr_auto;
    assign target_pkt = ptr_rxsel ? rx_head_pkt : pkt_q;

    ppp_ptr_reg #(.PKT_W(PKT_W), .OFF_W(OFF_W), .LOC_W(LOC_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_wr   (pkt_wr),
        .pkt_in   (wdata[PKT_W-1:0]),
        .ptr_wr   (ptr_wr),
        .flags_in ({wdata[BIT_RXSEL], wdata[BIT_AUTO], wdata[BIT_READ]}),
        .off_in   (wdata[LOC_W-1:0]),
        .adv      (adv),
        .adv_byte (acc_byte),
        .pkt_q    (pkt_q),
        .rx_sel   (ptr_rxsel),
        .auto_inc (ptr_auto),
        .rd_mode  (ptr_read),
        .off_q    (ptr_off)
    );

    ppp_addr_gen #(.PKT_W(PKT_W), .LOC_W(LOC_W), .AW(AW)) u_addr (
        .pkt       (target_pkt),
        .loc       (ptr_off[LOC_W-1:0]),
        .lane_addr (lane_addr)
    );

    ppp_pkt_ram #(.AW(AW)) u_ram (
        .clk   (clk),
        .wr_lo (data_wr_ok),
        .wr_hi (data_wr_ok && !acc_byte),
        .addr  (lane_addr),
        .wdata (wdata),
        .rd_en (fetch_en),
        .rd_lo (ram_lo),
        .rd_hi (ram_hi)
    );

    ppp_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_wr      (ptr_wr),
        .ptr_wr_read (wdata[BIT_READ]),
        .pkt_wr      (pkt_wr),
        .rd_mode     (ptr_read),
        .rd_adv      (data_rd_ok && ptr_auto),
        .state_q     (state_q),
        .busy        (busy),
        .fetch_en    (fetch_en),
        .data_ready  (data_ready)
    );

    always_comb begin
        ptr_view             = '0;
        ptr_view[OFF_W-1:0]  = ptr_off;
        ptr_view[BIT_RXSEL]  = ptr_rxsel;
        ptr_view[BIT_AUTO]   = ptr_auto;
        ptr_view[BIT_READ]   = ptr_read;
    end

    always_comb begin
        rdata = '0;
        unique case (reg_sel)
            SEL_PKT:  rdata = 16'(pkt_q);
            SEL_PTR:  rdata = ptr_view;
            SEL_DATA: if (data_ready && ptr_read) begin
                          rdata = acc_byte ? {8'h00, ram_lo} : {ram_hi, ram_lo};
                      end
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ppp_port_chk.sv
module ppp_port_chk
    import ppp_pkg::*;
#(
    parameter int OFF_W     = 11,
    parameter int PKT_BYTES = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_sel,
    input logic             rd_en,
    input logic             wr_en,
    input logic             acc_byte,
    input logic [15:0]      wdata,
    input logic             busy,
    input logic             ptr_auto,
    input logic             ptr_read,
    input logic [OFF_W-1:0] ptr_off
);

    localparam logic [OFF_W-1:0] MASK_L = OFF_W'(PKT_BYTES - 1);

    logic [OFF_W-1:0] exp_b, exp_w;
    logic             ptr_w, rd_go;

    assign exp_b = (ptr_off + OFF_W'(1)) & MASK_L;
    assign exp_w = (ptr_off + OFF_W'(2)) & MASK_L;
    assign ptr_w = wr_en && (reg_sel == SEL_PTR);
    assign rd_go = rd_en && (reg_sel == SEL_DATA) && ptr_auto && ptr_read && !busy && !ptr_w;

    p_fetch_after_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_w && wdata[BIT_READ]) |=> busy);

    p_busy_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en) |=> !busy);

    p_hold_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_auto && !ptr_w) |=> $stable(ptr_off));

    p_byte_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && acc_byte) |=> (ptr_off == $past(exp_b)));

    p_word_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !acc_byte) |=> (ptr_off == $past(exp_w)));

    p_ignore_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (reg_sel == SEL_DATA) && !ptr_read && !wr_en) |=> $stable(ptr_off));

endmodule

bind ppp_data_port ppp_port_chk #(.OFF_W(OFF_W), .PKT_BYTES(PKT_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .acc_byte (acc_byte),
    .wdata    (wdata),
    .busy     (busy),
    .ptr_auto (ptr_auto),
    .ptr_read (ptr_read),
    .ptr_off  (ptr_off)
);

// File: tb/ppp_data_port_tb.sv
module ppp_data_port_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0, acc_byte = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;
    logic [1:0]  rx_head_pkt = '0;

    int n_checks = 0;
    int n_errs   = 0;
    logic mon_req = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ppp_data_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .acc_byte(acc_byte), .wdata(wdata), .rdata(rdata), .busy(busy),
        .rx_head_pkt(rx_head_pkt)
    );

    // Monitor: pops the scoreboard when a read is on the bus.
    initial forever begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (mon_req && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rdata !== e) begin
                n_errs++;
                $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic drive(input logic [1:0] s, input logic r, input logic w,
                         input logic b, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; rd_en = r; wr_en = w; acc_byte = b; wdata = d; mon_req = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic b, input logic [15:0] d);
        drive(s, 1'b0, 1'b1, b, d);
    endtask

    task automatic rd(input logic [1:0] s, input logic b, input logic [15:0] e, input string t);
        drive(s, 1'b1, 1'b0, b, 16'h0);
        exp_q.push_back(e);
        tag_q.push_back(t);
        mon_req = 1'b1;
    endtask

    task automatic idle_busy(input logic e, input string t);
        drive(2'd0, 1'b0, 1'b0, 1'b0, 16'h0);
        #(CLK_PERIOD/4);
        n_checks++;
        if (busy !== e) begin
            n_errs++;
            $display("FAIL %s: busy actual %b expected %b", t, busy, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state, R11 unused select
        rd(2'd0, 0, 16'h0000, "R1");
        rd(2'd1, 0, 16'h0000, "R1");
        idle_busy(1'b0, "R1");
        rd(2'd3, 0, 16'h0000, "R11");

        // R2 packet number readback; R4/R5/R6 writes with auto-increment
        wr(2'd0, 0, 16'h0001);
        rd(2'd0, 0, 16'h0001, "R2");
        wr(2'd1, 0, 16'h4000);
        wr(2'd2, 0, 16'h0201);
        wr(2'd2, 0, 16'h0403);
        wr(2'd2, 1, 16'hEE05);
        rd(2'd1, 0, 16'h4005, "R6");
        wr(2'd2, 0, 16'h0706);
        rd(2'd1, 0, 16'h4007, "R6");

        // R9 prefetch, R4 word order, R5 byte read
        wr(2'd1, 0, 16'h6000);
        idle_busy(1'b1, "R9");
        rd(2'd2, 0, 16'h0201, "R4");
        idle_busy(1'b1, "R9");
        rd(2'd2, 1, 16'h0003, "R5");
        idle_busy(1'b1, "R9");
        rd(2'd2, 0, 16'h0504, "R4");
        idle_busy(1'b1, "R9");
        rd(2'd1, 0, 16'h6005, "R6");

        // R7 no auto-increment
        wr(2'd1, 0, 16'h2000);
        idle_busy(1'b1, "R9");
        rd(2'd2, 0, 16'h0201, "R7");
        rd(2'd2, 0, 16'h0201, "R7");
        rd(2'd1, 0, 16'h2000, "R7");

        // R10 wrong-direction accesses
        wr(2'd1, 0, 16'h6000);
        idle_busy(1'b1, "R9");
        wr(2'd2, 0, 16'hFFFF);
        rd(2'd1, 0, 16'h6000, "R10");
        rd(2'd2, 0, 16'h0201, "R10");
        idle_busy(1'b1, "R9");
        wr(2'd1, 0, 16'h4010);
        rd(2'd2, 0, 16'h0000, "R10");
        rd(2'd1, 0, 16'h4010, "R10");

        // R8 wrap, R2 unused pointer bits
        wr(2'd1, 0, 16'h1FFF);
        rd(2'd1, 0, 16'h01FF, "R2");
        wr(2'd1, 0, 16'h47FF);
        rd(2'd1, 0, 16'h41FF, "R8");
        wr(2'd2, 0, 16'hBBAA);
        rd(2'd1, 0, 16'h4001, "R8");
        wr(2'd1, 0, 16'h2000);
        idle_busy(1'b1, "R9");
        rd(2'd2, 0, 16'h02BB, "R8");
        wr(2'd1, 0, 16'h21FF);
        idle_busy(1'b1, "R9");
        rd(2'd2, 0, 16'hBBAA, "R8");

        // R3 receive-head selection; R9 refetch on packet-number write
        wr(2'd0, 0, 16'h0002);
        wr(2'd1, 0, 16'h4000);
        wr(2'd2, 0, 16'h1234);
        wr(2'd0, 0, 16'h0001);
        rx_head_pkt = 2'd2;
        wr(2'd1, 0, 16'hA000);
        idle_busy(1'b1, "R9");
        rd(2'd2, 0, 16'h1234, "R3");
        rd(2'd1, 0, 16'hA000, "R2");
        wr(2'd1, 0, 16'h2000);
        idle_busy(1'b1, "R9");
        rd(2'd2, 0, 16'h02BB, "R3");
        wr(2'd0, 0, 16'h0002);
        idle_busy(1'b1, "R9");
        rd(2'd2, 0, 16'h1234, "R9");

        // R10 accesses while busy are ignored
        wr(2'd1, 0, 16'h6000);
        rd(2'd2, 0, 16'h0000, "R10");
        rd(2'd1, 0, 16'h6000, "R10");
        rd(2'd2, 0, 16'h1234, "R9");

        drive(2'd0, 1'b0, 1'b0, 1'b0, 16'h0);
        #(CLK_PERIOD);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule